// File: doc/BRIEF.md
# Protection Unit Region Register File

This block is the software-visible configuration store of a small memory protection unit. A processor writes and reads it through a simple word-wide register port. For every region it keeps a base address and an attribute word. It also holds three global control bits and a constant identification word that reports how many regions are built in. All stored region fields and control bits are driven out in parallel, so a separate access checker can evaluate every region in the same cycle.

Software picks a region by writing a region selector. Later base and attribute accesses then go to that region. A base write can also carry a valid flag with its own region number. That write moves the selector and programs the base in one access, so no separate selector write is needed. Reads are combinational from the current offset. Writes take effect at the next rising clock edge.

Top module: `prot_region_regs`

## Requirements
- R1: After reset the control word reads 0, the selector reads 0, and every region enable output is 0.
- R2: The identification word at offset 0 reads the region count in bits [15:8] and zero in every other bit. Writes to it change nothing.
- R3: The control word at offset 1 stores bits [2:0]: bit 0 drives `unit_en_o`, bit 1 drives `fault_keep_o` and bit 2 drives `priv_bg_o`. Bits [31:3] read zero.
- R4: A write to the selector at offset 2 takes bits [7:0] when that value is below the region count. A value at or above the count leaves the selector unchanged. The selector reads back zero-extended.
- R5: A write to the base word at offset 3 with bit 4 clear stores bits [31:5] as the base of the selected region. Bits [3:0] are ignored and the selector is unchanged.
- R6: A write to the base word with bit 4 set and bits [3:0] below the region count first sets the selector to bits [3:0], then stores bits [31:5] into that region. If bits [3:0] are at or above the count, the whole write is ignored.
- R7: A read of the base word returns the selected region's base in [31:5], zero in bit 4, and the selector in [3:0].
- R8: A write to the attribute word at offset 4 stores, for the selected region, bit 28 (no-execute), bits [26:24] (access code), bits [15:8] (subregion-disable mask), bits [5:1] (size code) and bit 0 (enable). A read returns those fields in the same positions, with all other bits zero.
- R9: The per-region outputs show each region's stored fields at slice i of each bus. A write to one region leaves every other region's outputs unchanged.
- R10: Offsets 5 to 7 read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| unit_en_o | output | 1 | Control bit 0 |
| fault_keep_o | output | 1 | Control bit 1, unit stays active in fault handlers |
| priv_bg_o | output | 1 | Control bit 2, privileged background map |
| rgn_en_o | output | NUM_REGIONS | Region enable bits |
| rgn_xn_o | output | NUM_REGIONS | Region no-execute bits |
| rgn_ap_o | output | 3*NUM_REGIONS | Region access codes |
| rgn_srd_o | output | 8*NUM_REGIONS | Region subregion-disable masks |
| rgn_size_o | output | 5*NUM_REGIONS | Region size codes |
| rgn_base_o | output | 27*NUM_REGIONS | Region base addresses divided by 32 |

## Verification
The bench targets the two ways a base write can choose its region. A design that ignored the valid flag would program the region the selector already points at and leave the selector unchanged. A design that honoured bits [3:0] without the flag would corrupt a different region. It also sends a valid base write and a selector write whose region number is out of range. A design without the range check would move the selector past the last region, or store a base into no real region. The attribute check uses all-ones data to confirm that reserved bits read zero, and then confirms that the previous region's fields did not move.

// File: rtl/prot_region_regs.sv
module prot_region_regs #(
  parameter int NUM_REGIONS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_we,
  input  logic [2:0]                 bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic                       unit_en_o,
  output logic                       fault_keep_o,
  output logic                       priv_bg_o,
  output logic [NUM_REGIONS-1:0]     rgn_en_o,
  output logic [NUM_REGIONS-1:0]     rgn_xn_o,
  output logic [3*NUM_REGIONS-1:0]   rgn_ap_o,
  output logic [8*NUM_REGIONS-1:0]   rgn_srd_o,
  output logic [5*NUM_REGIONS-1:0]   rgn_size_o,
  output logic [27*NUM_REGIONS-1:0]  rgn_base_o
);

  localparam int SEL_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam logic [8:0] NREG9 = NUM_REGIONS[8:0];
  localparam logic [2:0] OFS_ID   = 3'd0;
  localparam logic [2:0] OFS_CTL  = 3'd1;
  localparam logic [2:0] OFS_SEL  = 3'd2;
  localparam logic [2:0] OFS_BASE = 3'd3;
  localparam logic [2:0] OFS_ATTR = 3'd4;

  logic [SEL_W-1:0] sel_q;
  logic [2:0]       ctl_q;
  logic [NUM_REGIONS-1:0] en_q;
  logic [NUM_REGIONS-1:0] xn_q;
  logic [2:0]  ap_q   [NUM_REGIONS];
  logic [7:0]  srd_q  [NUM_REGIONS];
  logic [4:0]  size_q [NUM_REGIONS];
  logic [26:0] base_q [NUM_REGIONS];

  wire wr      = bus_sel & bus_we;
  wire wr_ctl  = wr && bus_addr == OFS_CTL;
  wire wr_sel  = wr && bus_addr == OFS_SEL;
  wire wr_base = wr && bus_addr == OFS_BASE;
  wire wr_attr = wr && bus_addr == OFS_ATTR;

  wire sel_ok   = {1'b0, bus_wdata[7:0]} < NREG9;
  wire tag_ok   = {5'b0, bus_wdata[3:0]} < NREG9;
  wire base_vld = bus_wdata[4];
  wire base_go  = wr_base & (~base_vld | tag_ok);
  wire [SEL_W-1:0] base_tgt = base_vld ? bus_wdata[SEL_W-1:0] : sel_q;
  wire [31:0] sel_ext = 32'(sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= bus_wdata[2:0];
      if (wr_sel && sel_ok) sel_q <= bus_wdata[SEL_W-1:0];
      else if (wr_base && base_vld && tag_ok) sel_q <= bus_wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      xn_q <= '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
        ap_q[i]   <= '0;
        srd_q[i]  <= '0;
        size_q[i] <= '0;
        base_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        if (base_go && base_tgt == SEL_W'(i)) base_q[i] <= bus_wdata[31:5];
        if (wr_attr && sel_q == SEL_W'(i)) begin
          xn_q[i]   <= bus_wdata[28];
          ap_q[i]   <= bus_wdata[26:24];
          srd_q[i]  <= bus_wdata[15:8];
          size_q[i] <= bus_wdata[5:1];
          en_q[i]   <= bus_wdata[0];
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        OFS_ID:   bus_rdata = {16'h0, NREG9[7:0], 8'h0};
        OFS_CTL:  bus_rdata = {29'h0, ctl_q};
        OFS_SEL:  bus_rdata = sel_ext;
        OFS_BASE: bus_rdata = {base_q[sel_q], 1'b0, sel_ext[3:0]};
        OFS_ATTR: bus_rdata = {3'b0, xn_q[sel_q], 1'b0, ap_q[sel_q], 8'h0,
                               srd_q[sel_q], 2'b0, size_q[sel_q], en_q[sel_q]};
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign unit_en_o    = ctl_q[0];
  assign fault_keep_o = ctl_q[1];
  assign priv_bg_o    = ctl_q[2];
  assign rgn_en_o     = en_q;
  assign rgn_xn_o     = xn_q;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_out
    assign rgn_ap_o[3*g +: 3]    = ap_q[g];
    assign rgn_srd_o[8*g +: 8]   = srd_q[g];
    assign rgn_size_o[5*g +: 5]  = size_q[g];
    assign rgn_base_o[27*g +: 27] = base_q[g];
  end

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (sel_q == '0 && ctl_q == '0 && en_q == '0));

  a_r3_ctl_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> {priv_bg_o, fault_keep_o, unit_en_o} == $past(bus_wdata[2:0]));

  a_r4_sel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, sel_ext[7:0]} < NREG9);

  a_r5_plain_base_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base && !bus_wdata[4]) |=> $stable(sel_q));

  a_r6_valid_base_moves_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base && bus_wdata[4] && tag_ok) |=> sel_ext[3:0] == $past(bus_wdata[3:0]));

  a_r8_attr_enable_stored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_attr |=> en_q[$past(sel_q)] == $past(bus_wdata[0]));

  a_r10_unmapped_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr > OFS_ATTR) |=> ($stable(sel_q) && $stable(ctl_q) && $stable(en_q)));

endmodule

// File: tb/prot_region_regs_bench.sv
module prot_region_regs_bench;
  localparam int N = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic unit_en_o, fault_keep_o, priv_bg_o;
  logic [N-1:0] rgn_en_o, rgn_xn_o;
  logic [3*N-1:0] rgn_ap_o;
  logic [8*N-1:0] rgn_srd_o;
  logic [5*N-1:0] rgn_size_o;
  logic [27*N-1:0] rgn_base_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prot_region_regs #(.NUM_REGIONS(N)) u_prot_region_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .unit_en_o(unit_en_o), .fault_keep_o(fault_keep_o), .priv_bg_o(priv_bg_o),
    .rgn_en_o(rgn_en_o), .rgn_xn_o(rgn_xn_o), .rgn_ap_o(rgn_ap_o),
    .rgn_srd_o(rgn_srd_o), .rgn_size_o(rgn_size_o), .rgn_base_o(rgn_base_o));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  function automatic logic [31:0] base_of(int r);
    return {5'b0, rgn_base_o[27*r +: 27]};
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd1, v); chk("R1 ctrl after reset", v, 0);
    rd(3'd2, v); chk("R1 selector after reset", v, 0);
    chk("R1 enables after reset", {24'b0, rgn_en_o}, 0);
  endtask

  task automatic t_ident;
    logic [31:0] v;
    rd(3'd0, v); chk("R2 identification word", v, 32'h0000_0800);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R2 identification after write", v, 32'h0000_0800);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R3 ctrl reserved bits zero", v, 32'h7);
    chk("R3 ctrl outputs all set", {29'b0, priv_bg_o, fault_keep_o, unit_en_o}, 32'h7);
    wr(3'd1, 32'h5);
    chk("R3 ctrl outputs 101", {29'b0, priv_bg_o, fault_keep_o, unit_en_o}, 32'h5);
  endtask

  task automatic t_selector;
    logic [31:0] v;
    wr(3'd2, 32'd3);
    rd(3'd2, v); chk("R4 selector set 3", v, 3);
    wr(3'd2, 32'd8);
    rd(3'd2, v); chk("R4 selector out of range ignored", v, 3);
    wr(3'd2, 32'd7);
    rd(3'd2, v); chk("R4 selector top region", v, 7);
  endtask

  task automatic t_base_plain;
    logic [31:0] v;
    wr(3'd2, 32'd2);
    wr(3'd3, 32'h1234_5665);
    rd(3'd2, v); chk("R5 selector unchanged", v, 2);
    chk("R5 base stored in region 2", base_of(2), 32'h1234_5665 >> 5);
    chk("R5 region 5 base untouched", base_of(5), 0);
    rd(3'd3, v); chk("R7 base readback", v, 32'h1234_5662);
  endtask

  task automatic t_base_valid;
    logic [31:0] v;
    wr(3'd3, 32'hABCD_E015);
    rd(3'd2, v); chk("R6 valid write moves selector", v, 5);
    chk("R6 base stored in region 5", base_of(5), 32'hABCD_E015 >> 5);
    chk("R6 region 2 base kept", base_of(2), 32'h1234_5665 >> 5);
    rd(3'd3, v); chk("R7 base readback valid clear", v, 32'hABCD_E005);
    wr(3'd3, 32'h4000_0019);
    rd(3'd2, v); chk("R6 out of range valid ignored selector", v, 5);
    chk("R6 out of range valid ignored base", base_of(5), 32'hABCD_E015 >> 5);
    chk("R6 region 1 base untouched", base_of(1), 0);
  endtask

  task automatic t_attr;
    logic [31:0] v;
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); chk("R8 attribute reserved bits zero", v, 32'h1700_FF3F);
    chk("R9 enables only region 5", {24'b0, rgn_en_o}, 32'h20);
    chk("R9 region 5 fields", {rgn_xn_o[5], rgn_ap_o[15 +: 3], rgn_srd_o[40 +: 8], rgn_size_o[25 +: 5]},
        {15'b0, 1'b1, 3'd7, 8'hFF, 5'd31});
    wr(3'd2, 32'd1);
    wr(3'd4, 32'h0300_A513);
    rd(3'd4, v); chk("R8 attribute region 1 readback", v, 32'h0300_A513);
    chk("R9 region 1 fields", {rgn_xn_o[1], rgn_ap_o[3 +: 3], rgn_srd_o[8 +: 8], rgn_size_o[5 +: 5]},
        {15'b0, 1'b0, 3'd3, 8'hA5, 5'd9});
    chk("R9 region 5 kept", {rgn_xn_o[5], rgn_ap_o[15 +: 3], rgn_srd_o[40 +: 8], rgn_size_o[25 +: 5]},
        {15'b0, 1'b1, 3'd7, 8'hFF, 5'd31});
    chk("R9 enables regions 1 and 5", {24'b0, rgn_en_o}, 32'h22);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd6, v); chk("R10 offset 6 reads zero", v, 0);
    rd(3'd7, v); chk("R10 offset 7 reads zero", v, 0);
    rd(3'd1, v); chk("R10 ctrl unchanged", v, 5);
    rd(3'd2, v); chk("R10 selector unchanged", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ident();
    t_ctrl();
    t_selector();
    t_base_plain();
    t_base_valid();
    t_attr();
    t_unmapped();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule